// File: doc/BRIEF.md
# Bridge Address Window Forwarding Decoder

This block decides, for a two-port bus-to-bus bridge, whether a transaction seen on either side should be claimed and passed across, and in which direction. Software programs typed address windows: I/O, non-prefetchable memory and prefetchable memory, with `WPK` windows of each kind. It also sets three command enable bits. Each window is a base/limit pair, and the block compares every request address against the windows of the request's type.

A request is presented with `req_valid`, its address, its type and the side it came from. The block registers the request. One cycle later it raises `rsp_valid` with the claim decision, which is computed combinationally from the registered request and the current configuration. A primary-side request whose address is inside a window of its type is forwarded downstream. A secondary-side request whose address is outside every window of its type is forwarded upstream. Addresses are never altered.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset the command bits are clear and every window is disabled (base all ones, limit zero), so no request is claimed from either side.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A primary-side I/O request (`req_is_mem`=0, `req_from_sec`=0) is claimed with `rsp_upstream`=0 when command bit 0 (I/O enable) is set and the address lies in an I/O window.
- R4: With command bit 0 clear, no primary-side I/O request is claimed.
- R5: A primary-side memory request is claimed downstream only when command bit 1 (memory enable) is set and the address lies in a non-prefetchable or prefetchable window.
- R6: A window matches when base <= address <= limit, both ends inclusive; a window with base > limit never matches.
- R7: I/O requests are compared only with the I/O windows and memory requests only with the two kinds of memory windows.
- R8: A secondary-side request is claimed with `rsp_upstream`=1 when command bit 2 (master enable) is set and the address lies in no window of its type.
- R9: With command bit 2 clear, no secondary-side request, I/O or memory, is claimed.
- R10: A write with `cfg_we` high loads `cfg_wdata` into register `cfg_sel`. Select 0 is the command register, with bit 0 as I/O enable, bit 1 as memory enable and bit 2 as master enable. Window w (w = kind*WPK + n, where kind 0 is I/O, kind 1 is non-prefetchable and kind 2 is prefetchable) takes its base at select 1+2w and its limit at select 2+2w.
- R11: `rsp_claim` and `rsp_upstream` are low whenever `rsp_valid` is low, and `rsp_upstream` is high only together with `rsp_claim` for a secondary-side request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Register select (command or window base/limit) |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | AW | Request address |
| req_is_mem | input | 1 | 1 = memory request, 0 = I/O request |
| req_from_sec | input | 1 | 1 = request seen on the secondary side |
| rsp_valid | output | 1 | Decision strobe, one cycle after the request |
| rsp_claim | output | 1 | Request is claimed and forwarded |
| rsp_upstream | output | 1 | Forwarding direction is secondary to primary |

## Verification
The bench uses the default parameters, AW = 32 and WPK = 2. That gives six windows, thirteen register selects and full 32-bit compares, so every select, both windows of each kind and overlap between kinds can all be reached. Random windows are kept narrow and the random addresses are clustered around them. This makes the inclusive edges, the values just outside them and disabled windows (base above limit) come up often. At the same time the command bits are reprogrammed at random between requests.

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder #(
  parameter int AW  = 32,
  parameter int WPK = 2,
  localparam int SELW = $clog2(1 + 6 * WPK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_is_mem,
  input  logic            req_from_sec,
  output logic            rsp_valid,
  output logic            rsp_claim,
  output logic            rsp_upstream
);
  localparam int NWIN = 3 * WPK;

  logic [2:0]    cmd_q;
  logic [AW-1:0] base_q [NWIN];
  logic [AW-1:0] lim_q  [NWIN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      for (int w = 0; w < NWIN; w++) begin
        base_q[w] <= '1;
        lim_q[w]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == '0) cmd_q <= cfg_wdata[2:0];
      for (int w = 0; w < NWIN; w++) begin
        if (cfg_sel == SELW'(1 + 2 * w)) base_q[w] <= cfg_wdata;
        if (cfg_sel == SELW'(2 + 2 * w)) lim_q[w]  <= cfg_wdata;
      end
    end
  end

  logic          vld_q, mem_q, sec_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mem_q  <= 1'b0;
      sec_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        mem_q  <= req_is_mem;
        sec_q  <= req_from_sec;
        addr_q <= req_addr;
      end
    end
  end

  logic [NWIN-1:0] in_win;
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign in_win[w] = (base_q[w] <= addr_q) && (addr_q <= lim_q[w]);
  end

  logic [NWIN-1:0] type_mask;
  assign type_mask = mem_q ? {{(2 * WPK){1'b1}}, {WPK{1'b0}}}
                           : {{(2 * WPK){1'b0}}, {WPK{1'b1}}};

  logic hit, allow, want;
  assign hit   = |(in_win & type_mask);
  assign allow = sec_q ? cmd_q[2] : (mem_q ? cmd_q[1] : cmd_q[0]);
  assign want  = sec_q ? ~hit : hit;

  assign rsp_valid    = vld_q;
  assign rsp_claim    = vld_q & allow & want;
  assign rsp_upstream = rsp_claim & sec_q;
endmodule

module bridge_window_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic       rsp_claim,
  input logic       rsp_upstream,
  input logic [2:0] cmd,
  input logic       side_sec,
  input logic       is_mem
);
  assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_claim && !rsp_upstream));
  assert_upstream_needs_claim_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_upstream |-> (rsp_claim && side_sec));
  assert_io_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !side_sec && !is_mem && !cmd[0]) |-> !rsp_claim);
  assert_mem_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !side_sec && is_mem && !cmd[1]) |-> !rsp_claim);
  assert_master_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && side_sec && !cmd[2]) |-> !rsp_claim);
  assert_downstream_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_claim && !side_sec) |-> !rsp_upstream);
endmodule

bind bridge_window_decoder bridge_window_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_claim(rsp_claim), .rsp_upstream(rsp_upstream), .cmd(cmd_q),
  .side_sec(sec_q), .is_mem(mem_q)
);

// File: tb/sim_bridge_window_decoder.sv
module sim_bridge_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int WPK  = 2;
  localparam int NWIN = 3 * WPK;
  localparam int SELW = $clog2(1 + 6 * WPK);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [SELW-1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_is_mem = 1'b0, req_from_sec = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_claim, rsp_upstream;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [2:0]    m_cmd;
  logic [AW-1:0] m_base [NWIN];
  logic [AW-1:0] m_lim  [NWIN];

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_window_decoder #(.AW(AW), .WPK(WPK)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_mem(req_is_mem), .req_from_sec(req_from_sec),
    .rsp_valid(rsp_valid), .rsp_claim(rsp_claim), .rsp_upstream(rsp_upstream)
  );

  function automatic logic [1:0] expect_dec(logic [AW-1:0] a, logic mem, logic sec);
    logic hit = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      int kind = w / WPK;
      if (((mem && kind != 0) || (!mem && kind == 0)) && m_base[w] <= a && a <= m_lim[w])
        hit = 1'b1;
    end
    if (sec) return (m_cmd[2] && !hit) ? 2'b11 : 2'b00;
    if (mem) return (m_cmd[1] && hit) ? 2'b10 : 2'b00;
    return (m_cmd[0] && hit) ? 2'b10 : 2'b00;
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: {valid,claim,up} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg_write(int sel, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SELW'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) m_cmd = d[2:0];
    else if (sel % 2 == 1) m_base[(sel - 1) / 2] = d;
    else m_lim[(sel - 2) / 2] = d;
  endtask

  task automatic set_win(int w, logic [AW-1:0] b, logic [AW-1:0] l);
    cfg_write(1 + 2 * w, b);
    cfg_write(2 + 2 * w, l);
  endtask

  task automatic apply(string req, logic [AW-1:0] a, logic mem, logic sec);
    logic [1:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_mem = mem; req_from_sec = sec;
    e = expect_dec(a, mem, sec);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {rsp_valid, rsp_claim, rsp_upstream}, {1'b1, e});
  endtask

  task automatic apply_fixed(string req, logic [AW-1:0] a, logic mem, logic sec, logic [1:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_mem = mem; req_from_sec = sec;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {rsp_valid, rsp_claim, rsp_upstream}, {1'b1, e});
  endtask

  initial begin
    void'($urandom(32'd20240607));
    m_cmd = '0;
    for (int w = 0; w < NWIN; w++) begin m_base[w] = '1; m_lim[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {rsp_valid, rsp_claim, rsp_upstream}, 3'b000);
    apply_fixed("R1 reset pri io",  32'h0000_0000, 1'b0, 1'b0, 2'b00);
    apply_fixed("R1 reset pri mem", 32'hFFFF_FFFF, 1'b1, 1'b0, 2'b00);
    apply_fixed("R1 reset sec io",  32'h1234_5678, 1'b0, 1'b1, 2'b00);
    apply_fixed("R1 reset sec mem", 32'h8000_0000, 1'b1, 1'b1, 2'b00);
    @(negedge clk);
    check("R2 strobe one cycle", {rsp_valid, rsp_claim, rsp_upstream}, 3'b000);

    set_win(0, 32'h0000_1000, 32'h0000_1FFF);
    set_win(1, 32'h0000_4000, 32'h0000_3FFF);
    set_win(2, 32'h8000_0000, 32'h80FF_FFFF);
    set_win(4, 32'hC000_0000, 32'hC000_FFFF);
    cfg_write(0, 32'h0);
    apply_fixed("R4 io disabled", 32'h0000_1800, 1'b0, 1'b0, 2'b00);
    apply_fixed("R9 master off",  32'h0000_9000, 1'b1, 1'b1, 2'b00);
    cfg_write(0, 32'h1);
    apply_fixed("R3 io in window",       32'h0000_1800, 1'b0, 1'b0, 2'b10);
    apply_fixed("R6 base inclusive",     32'h0000_1000, 1'b0, 1'b0, 2'b10);
    apply_fixed("R6 limit inclusive",    32'h0000_1FFF, 1'b0, 1'b0, 2'b10);
    apply_fixed("R6 above limit",        32'h0000_2000, 1'b0, 1'b0, 2'b00);
    apply_fixed("R6 below base",         32'h0000_0FFF, 1'b0, 1'b0, 2'b00);
    apply_fixed("R6 disabled window",    32'h0000_4000, 1'b0, 1'b0, 2'b00);
    apply_fixed("R5 mem enable clear",   32'h8000_0010, 1'b1, 1'b0, 2'b00);
    apply_fixed("R7 io vs mem window",   32'h8000_0010, 1'b0, 1'b0, 2'b00);
    cfg_write(0, 32'h2);
    apply_fixed("R5 np mem window",      32'h80FF_FFFF, 1'b1, 1'b0, 2'b10);
    apply_fixed("R5 pf mem window",      32'hC000_0000, 1'b1, 1'b0, 2'b10);
    apply_fixed("R7 mem vs io window",   32'h0000_1800, 1'b1, 1'b0, 2'b00);
    apply_fixed("R4 io off mem on",      32'h0000_1800, 1'b0, 1'b0, 2'b00);
    cfg_write(0, 32'h4);
    apply_fixed("R8 sec mem outside",    32'h0000_1800, 1'b1, 1'b1, 2'b11);
    apply_fixed("R8 sec mem inside pf",  32'hC000_0100, 1'b1, 1'b1, 2'b00);
    apply_fixed("R8 sec io inside",      32'h0000_1000, 1'b0, 1'b1, 2'b00);
    apply_fixed("R8 sec io outside",     32'hC000_0100, 1'b0, 1'b1, 2'b11);
    apply_fixed("R11 pri with master",   32'h0000_1800, 1'b0, 1'b0, 2'b00);
    set_win(5, 32'h0000_0100, 32'h0000_0100);
    apply_fixed("R10 last window single",32'h0000_0100, 1'b1, 1'b1, 2'b00);
    cfg_write(0, 32'h3);
    apply_fixed("R10 last window pri",   32'h0000_0100, 1'b1, 1'b0, 2'b10);

    for (int i = 0; i < 400; i++) begin
      int w = int'($urandom % NWIN);
      logic [AW-1:0] a;
      if (i % 25 == 0) begin
        logic [AW-1:0] b = $urandom;
        logic [AW-1:0] l = ($urandom % 5 == 0) ? b - 1 : b + ($urandom % 64);
        set_win(w, b, l);
      end
      if (i % 17 == 0) cfg_write(0, AW'($urandom % 8));
      a = m_base[int'($urandom % NWIN)] + AW'($urandom % 80) - AW'(8);
      apply("R3/R5/R6/R7/R8 random", a, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule